// File: doc/BRIEF.md
# I2C Master Event Status and Interrupt Unit

This block sits beside an I2C master transaction engine. It collects the engine's one-cycle event pulses into a sticky status word. The events are a finished transaction, an address or data NACK, a NACK on the high-speed master code, lost arbitration, and the end of one message in a chained run. Software reads the status word and clears any bit by writing a one to it. A mask word selects which status bits may drive the single interrupt line.

A NACK does not close the report by itself. The engine follows it with a completion pulse, and both bits stay set side by side until software clears them. The per-message restart event is recorded only while automatic restart chaining is enabled. When chaining is disabled, that event input is dropped.

A third write target is a self-clearing command word. Writing it produces one-cycle pulses toward the engine:
- a transaction start;
- a chained-message trigger;
- a flag that says more messages follow.

Top module: `i2cm_evt_irq`

## Requirements
- R1: While reset is held, status, mask, interrupt and all three command pulses are zero.
- R2: An event pulse on `evt_i` bit k sets `status_o` bit k on the next clock edge, and the bit stays set until it is cleared. The bit encoding is: 0 transaction done, 1 ACK error, 2 high-speed master-code NACK, 3 arbitration lost, 4 message restart done.
- R3: A write with `cfg_sel_i` = 0 clears each `status_o` bit whose `cfg_wdata_i` bit is 1. All other status bits keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write with `cfg_sel_i` = 1 loads `cfg_wdata_i[4:0]` into `mask_o`. `irq_o` is the registered OR of (status AND mask), so it rises one cycle after an enabled bit is set. Status bits that are masked off never raise `irq_o`.
- R6: `irq_o` falls one cycle after the last enabled status bit is cleared.
- R7: An ACK-error pulse followed by a done pulse leaves both bits 1 and 0 set together.
- R8: While `auto_rs_en_i` is 0, an event on `evt_i[4]` has no effect on `status_o[4]`. While `auto_rs_en_i` is 1, the event sets it.
- R9: A write with `cfg_sel_i` = 2 produces a one-cycle pulse, on the next cycle, for each of these data bits written as 1:
  - bit 0 drives `go_start_o`;
  - bit 14 drives `go_multi_trig_o`;
  - bit 15 drives `go_multi_cfg_o`.
- R10: The command pulses clear themselves after one cycle. Writes to select codes 0 and 1 produce no command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 5 | One-cycle event pulses from the engine |
| auto_rs_en_i | input | 1 | Automatic restart chaining enabled |
| cfg_we_i | input | 1 | Write strobe |
| cfg_sel_i | input | 2 | Write target: 0 status clear, 1 mask, 2 command |
| cfg_wdata_i | input | 16 | Write data |
| status_o | output | 5 | Sticky event status |
| mask_o | output | 5 | Interrupt enable mask |
| irq_o | output | 1 | Interrupt request |
| go_start_o | output | 1 | Transaction start pulse |
| go_multi_trig_o | output | 1 | Chained-message trigger pulse |
| go_multi_cfg_o | output | 1 | More-messages-follow pulse |

## Verification
A status bit that fails to latch, or that clears itself, appears on `status_o` one cycle after the event or the unrelated write. The wrong `irq_o` level follows one cycle later. A lost set/clear priority shows as a zero on the colliding bit right after the collision. A command pulse that sticks or goes missing appears on the `go_*` outputs in the cycle after the write. Each of these is compared in that exact cycle against a model of the ports.

// File: rtl/i2cm_evt_pkg.sv
`timescale 1ns/1ps
package i2cm_evt_pkg;
  localparam int unsigned EVT_W  = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned GO_N   = 3;

  // status bit positions (decoded by software)
  localparam int unsigned BIT_DONE   = 0;
  localparam int unsigned BIT_ACKERR = 1;
  localparam int unsigned BIT_HSNACK = 2;
  localparam int unsigned BIT_ARB    = 3;
  localparam int unsigned BIT_RSDONE = 4;

  // command word bit positions: start, chained trigger, more-follow
  localparam int unsigned GO_POS [GO_N] = '{0, 14, 15};

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CMD    = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/evt_sticky.sv
`timescale 1ns/1ps
module evt_sticky #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           sts_q[k] <= 1'b0;
      else if (set_i[k]) sts_q[k] <= 1'b1;   // set wins over clear
      else if (clr_i[k]) sts_q[k] <= 1'b0;
    end

    p_latch_r2: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> sts_q[k]);
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
      (sts_q[k] && !clr_i[k]) |=> sts_q[k]);
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (clr_i[k] && !set_i[k]) |=> !sts_q[k]);
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/irq_merge.sv
`timescale 1ns/1ps
module irq_merge #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] msk_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_i & msk_i);
  end

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (|(sts_i & msk_i)) |=> irq_q);
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (rst)
    !(|(sts_i & msk_i)) |=> !irq_q);

  assign irq_o = irq_q;
endmodule

// File: rtl/cmd_pulse.sv
`timescale 1ns/1ps
module cmd_pulse
  import i2cm_evt_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [GO_N-1:0] go_o
);
  logic [GO_N-1:0] go_d, go_q;

  for (genvar k = 0; k < GO_N; k++) begin : g_go
    localparam logic [DW-1:0] PICK = DW'(1) << GO_POS[k];
    assign go_d[k] = we_i & (|(wdata_i & PICK));

    always_ff @(posedge clk) begin
      if (rst) go_q[k] <= 1'b0;
      else     go_q[k] <= go_d[k];   // self-clearing pulse
    end

    p_self_clear_r10: assert property (@(posedge clk) disable iff (rst)
      (go_q[k] && !go_d[k]) |=> !go_q[k]);
    p_no_cmd_r10: assert property (@(posedge clk) disable iff (rst)
      !we_i |=> !go_q[k]);
  end

  assign go_o = go_q;
endmodule

// File: rtl/i2cm_evt_irq.sv
`timescale 1ns/1ps
module i2cm_evt_irq
  import i2cm_evt_pkg::*;
#(
  parameter int unsigned EW = EVT_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] evt_i,
  input  logic          auto_rs_en_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [EW-1:0] status_o,
  output logic [EW-1:0] mask_o,
  output logic          irq_o,
  output logic          go_start_o,
  output logic          go_multi_trig_o,
  output logic          go_multi_cfg_o
);
  localparam logic [EW-1:0] RS_ONLY = EW'(1) << BIT_RSDONE;

  cfg_sel_e        sel;
  logic [EW-1:0]   evt_gated, clr_vec, mask_q, sts;
  logic [GO_N-1:0] go;
  logic            wr_sts, wr_msk, wr_cmd;

  assign sel    = cfg_sel_e'(cfg_sel_i);
  assign wr_sts = cfg_we_i && (sel == SEL_STATUS);
  assign wr_msk = cfg_we_i && (sel == SEL_MASK);
  assign wr_cmd = cfg_we_i && (sel == SEL_CMD);

  // restart-done event only counts while chaining is on
  assign evt_gated = evt_i & ~(auto_rs_en_i ? '0 : RS_ONLY);
  assign clr_vec   = wr_sts ? cfg_wdata_i[EW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (wr_msk) mask_q <= cfg_wdata_i[EW-1:0];
  end

  evt_sticky #(.W(EW)) u_sticky (
    .clk(clk), .rst(rst), .set_i(evt_gated), .clr_i(clr_vec), .sts_o(sts)
  );

  irq_merge #(.W(EW)) u_irq (
    .clk(clk), .rst(rst), .sts_i(sts), .msk_i(mask_q), .irq_o(irq_o)
  );

  cmd_pulse #(.DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .we_i(wr_cmd), .wdata_i(cfg_wdata_i), .go_o(go)
  );

  assign status_o        = sts;
  assign mask_o          = mask_q;
  assign go_start_o      = go[0];
  assign go_multi_trig_o = go[1];
  assign go_multi_cfg_o  = go[2];

  p_rs_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!auto_rs_en_i && !status_o[BIT_RSDONE]) |=> !status_o[BIT_RSDONE]);
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_msk |=> $stable(mask_o));
  p_nack_then_done_r7: assert property (@(posedge clk) disable iff (rst)
    (status_o[BIT_ACKERR] && evt_i[BIT_DONE] && !wr_sts) |=>
      (status_o[BIT_ACKERR] && status_o[BIT_DONE]));
endmodule

// File: tb/i2cm_evt_irq_bench.sv
`timescale 1ns/1ps
module i2cm_evt_irq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  evt = '0;
  logic        auto_rs = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd3;
  logic [15:0] wdata = '0;
  logic [4:0]  status, mask;
  logic        irq, go_s, go_t, go_c;

  always #5 clk = ~clk;

  i2cm_evt_irq u_i2cm_evt_irq (
    .clk(clk), .rst(rst), .evt_i(evt), .auto_rs_en_i(auto_rs),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wdata),
    .status_o(status), .mask_o(mask), .irq_o(irq),
    .go_start_o(go_s), .go_multi_trig_o(go_t), .go_multi_cfg_o(go_c)
  );

  typedef struct {
    int          cyc;
    int          kind;   // 0 status, 1 mask, 2 irq, 3 pulses {cfg,trig,start}
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [4:0]  m_sts = '0, m_msk = '0;
  logic [15:0] act;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0: return {11'd0, status};
      1: return {11'd0, mask};
      2: return {15'd0, irq};
      default: return {13'd0, go_c, go_t, go_s};
    endcase
  endfunction

  // monitor: pops every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        act = observe(sbq[i].kind);
        n_chk++;
        if (act !== sbq[i].exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                   sbq[i].tag, sbq[i].kind, cyc, act, sbq[i].exp);
        end
        sbq.delete(i);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the model's results
  task automatic step(input logic w, input logic [1:0] s, input logic [15:0] d,
                      input logic [4:0] e, input logic ars, input string tag);
    logic [4:0] clr, setv;
    logic [2:0] pul;
    @(posedge clk); #2;
    we = w; sel = s; wdata = d; evt = e; auto_rs = ars;
    clr  = (w && s == 2'd0) ? d[4:0] : 5'd0;
    setv = e & {ars, 4'hF};
    m_sts = (m_sts & ~clr) | setv;
    if (w && s == 2'd1) m_msk = d[4:0];
    pul = (w && s == 2'd2) ? {d[15], d[14], d[0]} : 3'd0;
    sbq.push_back('{cyc + 1, 0, {11'd0, m_sts}, tag});
    sbq.push_back('{cyc + 1, 1, {11'd0, m_msk}, tag});
    sbq.push_back('{cyc + 1, 3, {13'd0, pul}, tag});
    sbq.push_back('{cyc + 2, 2, {15'd0, |(m_sts & m_msk)}, tag});
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd3, 16'h0, 5'h0, auto_rs, tag);
  endtask

  task automatic chk_now(input string tag, input logic [15:0] a, input logic [15:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_now("R1", {11'd0, status}, 16'h0);
    chk_now("R1", {11'd0, mask}, 16'h0);
    chk_now("R1", {13'd0, go_c, go_t, go_s}, 16'h0);
    chk_now("R1", {15'd0, irq}, 16'h0);
    rst = 1'b0;

    // R2: latch and hold
    step(1'b0, 2'd3, 16'h0, 5'h01, 1'b0, "R2");
    idle("R2"); idle("R2");
    step(1'b0, 2'd3, 16'h0, 5'h08, 1'b0, "R2");
    idle("R2");
    // R5: enable mask, irq follows
    step(1'b1, 2'd1, 16'hFFFF, 5'h0, 1'b0, "R5");
    idle("R5"); idle("R5");
    // R3: clear only bit0; R6: clear rest, irq falls
    step(1'b1, 2'd0, 16'h0001, 5'h0, 1'b0, "R3");
    idle("R3");
    step(1'b1, 2'd0, 16'h0008, 5'h0, 1'b0, "R6");
    idle("R6"); idle("R6");
    // R7: NACK then completion, both kept
    step(1'b0, 2'd3, 16'h0, 5'h02, 1'b0, "R7");
    step(1'b0, 2'd3, 16'h0, 5'h01, 1'b0, "R7");
    idle("R7"); idle("R7");
    step(1'b1, 2'd0, 16'h0003, 5'h0, 1'b0, "R3");
    idle("R3");
    // R4: set and clear collide
    step(1'b0, 2'd3, 16'h0, 5'h08, 1'b0, "R4");
    step(1'b1, 2'd0, 16'h0008, 5'h08, 1'b0, "R4");
    idle("R4");
    step(1'b1, 2'd0, 16'h001F, 5'h04, 1'b0, "R4");
    idle("R4");
    step(1'b1, 2'd0, 16'h001F, 5'h0, 1'b0, "R4");
    idle("R4");
    // R8: restart event gated by chaining enable
    step(1'b0, 2'd3, 16'h0, 5'h10, 1'b0, "R8");
    idle("R8"); idle("R8");
    step(1'b0, 2'd3, 16'h0, 5'h10, 1'b1, "R8");
    idle("R8"); idle("R8");
    step(1'b1, 2'd0, 16'h0010, 5'h0, 1'b1, "R8");
    idle("R8"); idle("R8");
    // R5: masked bits do not raise irq
    step(1'b1, 2'd1, 16'h0002, 5'h0, 1'b0, "R5");
    step(1'b0, 2'd3, 16'h0, 5'h0D, 1'b0, "R5");
    idle("R5"); idle("R5");
    step(1'b0, 2'd3, 16'h0, 5'h02, 1'b0, "R5");
    idle("R5"); idle("R5");
    // R9/R10: command pulses
    step(1'b1, 2'd2, 16'hC001, 5'h0, 1'b0, "R9");
    idle("R10"); idle("R10");
    step(1'b1, 2'd2, 16'h4000, 5'h0, 1'b0, "R9");
    step(1'b1, 2'd2, 16'h8001, 5'h0, 1'b0, "R9");
    idle("R10");
    step(1'b1, 2'd2, 16'h3FFE, 5'h0, 1'b0, "R9");
    step(1'b1, 2'd1, 16'hC001, 5'h0, 1'b0, "R10");
    step(1'b1, 2'd0, 16'hC01F, 5'h0, 1'b0, "R10");
    idle("R10"); idle("R10");

    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d expectations never compared, actual=%0d expected=0",
               sbq.size(), sbq.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule